// File: doc/BRIEF.md
# Working Register File with Pointer Pairs

This block holds the 32 eight-bit working registers of a small microcontroller datapath. Decode logic reads two operands at once through two combinational read ports and writes results back through an 8-bit write port. A separate 16-bit path writes a consecutive register pair in one cycle. It carries the two bytes of a multiply product and the result of word add or subtract operations.

The registers also appear in data space at the lowest 32 byte addresses, so load and store units reach them through a memory-mapped port. The six highest registers are also presented as three 16-bit address pointers that the load/store unit uses for indirect addressing. An immediate-load write may only target the upper sixteen registers. A request aimed lower is flagged and discarded.

Top module: `gpr_bank`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) clears all 32 registers to 0x00.
- R2: Both read ports return the register selected by their 5-bit address. When that register is being written in the same cycle, they return the value being written (write-first).
- R3: A memory access with `mem_en` high and `mem_addr` in 0x0000 to 0x001F raises `mem_hit` and maps to the register whose index is `mem_addr[4:0]`. A read returns that register's content, with the same write-first rule as R2. A store (`mem_we` high) updates it. For any other address, or with `mem_en` low, `mem_hit` and `mem_rdata` are 0 and no register changes.
- R4: `ptr_x` is {r27, r26}, `ptr_y` is {r29, r28} and `ptr_z` is {r31, r30}, with the high byte on the left. They show stored values, so a write appears on them one cycle after its clock edge.
- R5: A byte write with `wr_imm` high is accepted only for registers 16 to 31. For registers 0 to 15, `imm_illegal` is high in that same cycle and the target register keeps its value. With `wr_imm` low, any register may be written.
- R6: A pair write (`pr_en` high) puts `pr_data[7:0]` into the even register `{pr_base[4:1],0}` and `pr_data[15:8]` into the odd register just above it. Bit 0 of `pr_base` is ignored. For example, base 0 stores a multiply result into r1:r0, and base 24 stores a word result into r25:r24.
- R7: When several writes hit one register in the same cycle, the pair write wins over the byte write port, and the byte write port wins over a memory store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_addr | input | 5 | Read port A register index |
| rd_a_data | output | 8 | Read port A data |
| rd_b_addr | input | 5 | Read port B register index |
| rd_b_data | output | 8 | Read port B data |
| wr_en | input | 1 | Byte write request |
| wr_imm | input | 1 | Byte write is an immediate load |
| wr_addr | input | 5 | Byte write register index |
| wr_data | input | 8 | Byte write data |
| imm_illegal | output | 1 | Immediate load aimed at r0 to r15 was refused |
| pr_en | input | 1 | Pair write request |
| pr_base | input | 5 | Pair base index (bit 0 ignored) |
| pr_data | input | 16 | Pair data, low byte to even register |
| mem_en | input | 1 | Data-space access valid |
| mem_we | input | 1 | Data-space access is a store |
| mem_addr | input | 16 | Data-space byte address |
| mem_wdata | input | 8 | Data-space store data |
| mem_hit | output | 1 | Access falls in the register window |
| mem_rdata | output | 8 | Data-space read data, 0 on a miss |
| ptr_x | output | 16 | Pointer from r27:r26 |
| ptr_y | output | 16 | Pointer from r29:r28 |
| ptr_z | output | 16 | Pointer from r31:r30 |

## Verification
The assertions assume the inputs hold a defined level at every sampled edge once reset is released, and that `rst` is held for at least one edge before any write is expected to matter. The bench drives every input on the falling edge from an initial block, with defined values only. It starts with reset asserted and an idle request set, so every input is known before the first edge. Random addresses are split between the register window and the wider 16-bit space, so both hits and misses of the window occur.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

  // default geometry of the working register file
  localparam int unsigned GPR_WIDTH  = 8;
  localparam int unsigned GPR_COUNT  = 32;
  localparam int unsigned GPR_IMM_LO = 16;
  localparam int unsigned GPR_PTR_LO = 26;
  localparam int unsigned GPR_NPTR   = 3;
  localparam int unsigned DSPACE_AW  = 16;

  // which requester owns a register's write in a given cycle
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_MEM  = 2'd1,
    SRC_BYTE = 2'd2,
    SRC_PAIR = 2'd3
  } wr_src_e;

endpackage

// File: rtl/gpr_wr_arb.sv
module gpr_wr_arb #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned AW       = $clog2(NUM_REGS)
) (
  input  logic                            byte_go,
  input  logic [AW-1:0]                   byte_idx,
  input  logic [DATA_W-1:0]               byte_data,
  input  logic                            pair_go,
  input  logic [AW-1:0]                   pair_idx,
  input  logic [2*DATA_W-1:0]             pair_data,
  input  logic                            mem_go,
  input  logic [AW-1:0]                   mem_idx,
  input  logic [DATA_W-1:0]               mem_data,
  output logic [NUM_REGS-1:0]             reg_we,
  output logic [NUM_REGS-1:0][DATA_W-1:0] reg_wd
);
  import gpr_pkg::*;

  // even and odd members of the addressed pair
  function automatic logic [AW-1:0] pair_low(input logic [AW-1:0] b);
    return {b[AW-1:1], 1'b0};
  endfunction

  function automatic logic [AW-1:0] pair_high(input logic [AW-1:0] b);
    return {b[AW-1:1], 1'b1};
  endfunction

  logic [AW-1:0] lo_idx;
  logic [AW-1:0] hi_idx;
  assign lo_idx = pair_low(pair_idx);
  assign hi_idx = pair_high(pair_idx);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    wr_src_e owner;

    // priority: pair, then byte port, then data-space store
    always_comb begin
      if (pair_go && (lo_idx == AW'(i) || hi_idx == AW'(i)))
        owner = SRC_PAIR;
      else if (byte_go && byte_idx == AW'(i))
        owner = SRC_BYTE;
      else if (mem_go && mem_idx == AW'(i))
        owner = SRC_MEM;
      else
        owner = SRC_NONE;
    end

    always_comb begin
      unique case (owner)
        SRC_PAIR: reg_wd[i] = (hi_idx == AW'(i)) ? pair_data[2*DATA_W-1:DATA_W]
                                                 : pair_data[DATA_W-1:0];
        SRC_BYTE: reg_wd[i] = byte_data;
        SRC_MEM:  reg_wd[i] = mem_data;
        default:  reg_wd[i] = '0;
      endcase
    end

    assign reg_we[i] = (owner != SRC_NONE);
  end

endmodule

// File: rtl/gpr_store.sv
module gpr_store #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_REGS = 32
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_REGS-1:0]             reg_we,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] reg_wd,
  output logic [NUM_REGS-1:0][DATA_W-1:0] reg_q
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst)
        reg_q[i] <= '0;
      else if (reg_we[i])
        reg_q[i] <= reg_wd[i];
    end
  end

endmodule

// File: rtl/gpr_rd_mux.sv
module gpr_rd_mux #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned AW       = $clog2(NUM_REGS)
) (
  input  logic [AW-1:0]                   sel,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] reg_q,
  input  logic [NUM_REGS-1:0]             reg_we,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] reg_wd,
  output logic [DATA_W-1:0]               dout
);

  // write-first: a pending write to the selected entry is forwarded
  assign dout = reg_we[sel] ? reg_wd[sel] : reg_q[sel];

endmodule

// File: rtl/gpr_bank.sv
module gpr_bank #(
  parameter int unsigned DATA_W    = gpr_pkg::GPR_WIDTH,
  parameter int unsigned NUM_REGS  = gpr_pkg::GPR_COUNT,
  parameter int unsigned IMM_FLOOR = gpr_pkg::GPR_IMM_LO,
  parameter int unsigned PTR_BASE  = gpr_pkg::GPR_PTR_LO,
  parameter int unsigned MEM_AW    = gpr_pkg::DSPACE_AW
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [$clog2(NUM_REGS)-1:0]       rd_a_addr,
  output logic [DATA_W-1:0]                 rd_a_data,
  input  logic [$clog2(NUM_REGS)-1:0]       rd_b_addr,
  output logic [DATA_W-1:0]                 rd_b_data,
  input  logic                              wr_en,
  input  logic                              wr_imm,
  input  logic [$clog2(NUM_REGS)-1:0]       wr_addr,
  input  logic [DATA_W-1:0]                 wr_data,
  output logic                              imm_illegal,
  input  logic                              pr_en,
  input  logic [$clog2(NUM_REGS)-1:0]       pr_base,
  input  logic [2*DATA_W-1:0]               pr_data,
  input  logic                              mem_en,
  input  logic                              mem_we,
  input  logic [MEM_AW-1:0]                 mem_addr,
  input  logic [DATA_W-1:0]                 mem_wdata,
  output logic                              mem_hit,
  output logic [DATA_W-1:0]                 mem_rdata,
  output logic [2*DATA_W-1:0]               ptr_x,
  output logic [2*DATA_W-1:0]               ptr_y,
  output logic [2*DATA_W-1:0]               ptr_z
);
  localparam int unsigned AW    = $clog2(NUM_REGS);
  localparam int unsigned PW    = 2 * DATA_W;
  localparam int unsigned NPTR  = gpr_pkg::GPR_NPTR;

  // named internal events, visible to the bound checker
  logic                            byte_go;
  logic                            mem_wr_hit;
  logic                            in_window;
  logic [NUM_REGS-1:0]             reg_we;
  logic [NUM_REGS-1:0][DATA_W-1:0] reg_wd;
  logic [NUM_REGS-1:0][DATA_W-1:0] reg_q;
  logic [DATA_W-1:0]               mem_rd_raw;
  logic [NPTR-1:0][PW-1:0]         ptr_bus;

  function automatic logic imm_target_ok(input logic [AW-1:0] idx);
    return 32'(idx) >= IMM_FLOOR;
  endfunction

  assign imm_illegal = wr_en && wr_imm && !imm_target_ok(wr_addr);
  assign byte_go     = wr_en && !imm_illegal;
  assign in_window   = (mem_addr[MEM_AW-1:AW] == '0);
  assign mem_hit     = mem_en && in_window;
  assign mem_wr_hit  = mem_hit && mem_we;

  gpr_wr_arb #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .AW(AW)) u_arb (
    .byte_go   (byte_go),
    .byte_idx  (wr_addr),
    .byte_data (wr_data),
    .pair_go   (pr_en),
    .pair_idx  (pr_base),
    .pair_data (pr_data),
    .mem_go    (mem_wr_hit),
    .mem_idx   (mem_addr[AW-1:0]),
    .mem_data  (mem_wdata),
    .reg_we    (reg_we),
    .reg_wd    (reg_wd)
  );

  gpr_store #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_store (
    .clk    (clk),
    .rst    (rst),
    .reg_we (reg_we),
    .reg_wd (reg_wd),
    .reg_q  (reg_q)
  );

  gpr_rd_mux #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .AW(AW)) u_rd_a (
    .sel (rd_a_addr), .reg_q (reg_q), .reg_we (reg_we), .reg_wd (reg_wd), .dout (rd_a_data)
  );

  gpr_rd_mux #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .AW(AW)) u_rd_b (
    .sel (rd_b_addr), .reg_q (reg_q), .reg_we (reg_we), .reg_wd (reg_wd), .dout (rd_b_data)
  );

  gpr_rd_mux #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .AW(AW)) u_rd_mem (
    .sel (mem_addr[AW-1:0]), .reg_q (reg_q), .reg_we (reg_we), .reg_wd (reg_wd), .dout (mem_rd_raw)
  );

  assign mem_rdata = mem_hit ? mem_rd_raw : '0;

  // pointer pairs from stored state, even register is the low byte
  for (genvar p = 0; p < NPTR; p++) begin : g_ptr
    assign ptr_bus[p] = {reg_q[PTR_BASE + 2*p + 1], reg_q[PTR_BASE + 2*p]};
  end

  assign ptr_x = ptr_bus[0];
  assign ptr_y = ptr_bus[1];
  assign ptr_z = ptr_bus[2];

endmodule

// File: rtl/gpr_bank_chk.sv
module gpr_bank_chk #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned AW       = 5
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  wr_en,
  input logic                  wr_imm,
  input logic [AW-1:0]         wr_addr,
  input logic [DATA_W-1:0]     wr_data,
  input logic                  imm_illegal,
  input logic                  pr_en,
  input logic [AW-1:0]         pr_base,
  input logic [2*DATA_W-1:0]   pr_data,
  input logic [AW-1:0]         rd_a_addr,
  input logic [DATA_W-1:0]     rd_a_data,
  input logic [AW-1:0]         rd_b_addr,
  input logic [DATA_W-1:0]     rd_b_data,
  input logic                  mem_hit,
  input logic                  mem_wr_hit,
  input logic [DATA_W-1:0]     mem_rdata,
  input logic [NUM_REGS-1:0]   reg_we,
  input logic [2*DATA_W-1:0]   ptr_x,
  input logic [2*DATA_W-1:0]   ptr_y,
  input logic [2*DATA_W-1:0]   ptr_z
);

  // R1: the cycle after reset is released every pointer reads zero
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (ptr_x == '0 && ptr_y == '0 && ptr_z == '0));

  // R2: a lone byte write is forwarded to a read port aimed at it
  p_bypass_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_imm && !pr_en && rd_b_addr == wr_addr) |-> (rd_b_data == wr_data));

  // R3: a miss of the register window reads as zero
  p_miss_zero_r3: assert property (@(posedge clk) disable iff (rst)
    !mem_hit |-> (mem_rdata == '0));

  // R4: with nothing written the pointers hold their values
  p_ptr_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !pr_en && !mem_wr_hit) |=> ($stable(ptr_x) && $stable(ptr_y) && $stable(ptr_z)));

  // R5: a refused immediate load does not reach the storage
  p_imm_block_r5: assert property (@(posedge clk) disable iff (rst)
    (imm_illegal && !pr_en && !mem_wr_hit) |-> !reg_we[wr_addr]);

  // R6: a pair write to r31:r30 shows on the Z pointer next cycle
  p_pair_to_ptr_r6: assert property (@(posedge clk) disable iff (rst)
    (pr_en && pr_base[AW-1:1] == '1) |=> (ptr_z == $past(pr_data)));

  // R7: pair write wins over a colliding byte write
  p_pair_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (pr_en && wr_en && !wr_imm && wr_addr[AW-1:1] == pr_base[AW-1:1] && rd_a_addr == wr_addr)
    |-> (rd_a_data == (wr_addr[0] ? pr_data[2*DATA_W-1:DATA_W] : pr_data[DATA_W-1:0])));

endmodule

bind gpr_bank gpr_bank_chk #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .AW(AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .wr_imm      (wr_imm),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .imm_illegal (imm_illegal),
  .pr_en       (pr_en),
  .pr_base     (pr_base),
  .pr_data     (pr_data),
  .rd_a_addr   (rd_a_addr),
  .rd_a_data   (rd_a_data),
  .rd_b_addr   (rd_b_addr),
  .rd_b_data   (rd_b_data),
  .mem_hit     (mem_hit),
  .mem_wr_hit  (mem_wr_hit),
  .mem_rdata   (mem_rdata),
  .reg_we      (reg_we),
  .ptr_x       (ptr_x),
  .ptr_y       (ptr_y),
  .ptr_z       (ptr_z)
);

// File: tb/gpr_bank_bench.sv
module gpr_bank_bench;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned RAND_STEPS = 3000;

  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  rd_a_addr, rd_b_addr, wr_addr, pr_base;
  logic [7:0]  rd_a_data, rd_b_data, wr_data, mem_wdata, mem_rdata;
  logic        wr_en, wr_imm, imm_illegal, pr_en, mem_en, mem_we, mem_hit;
  logic [15:0] pr_data, mem_addr, ptr_x, ptr_y, ptr_z;

  int unsigned n_checks = 0;
  int unsigned n_bad    = 0;
  logic [7:0]  mdl [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpr_bank u_gpr_bank (
    .clk(clk), .rst(rst),
    .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_imm(wr_imm), .wr_addr(wr_addr), .wr_data(wr_data),
    .imm_illegal(imm_illegal),
    .pr_en(pr_en), .pr_base(pr_base), .pr_data(pr_data),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_hit(mem_hit), .mem_rdata(mem_rdata),
    .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z)
  );

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_imm = 0; wr_addr = 0; wr_data = 0;
    pr_en = 0; pr_base = 0; pr_data = 0;
    mem_en = 0; mem_we = 0; mem_addr = 0; mem_wdata = 0;
    rd_a_addr = 0; rd_b_addr = 0;
  endtask

  // bench view of the rules: apply requests lowest priority first
  function automatic logic imm_refused();
    return wr_en && wr_imm && (wr_addr < 5'd16);
  endfunction

  function automatic logic window_hit();
    return mem_en && (mem_addr < 16'd32);
  endfunction

  // inputs are set; check combinational outputs, then clock and update model
  task automatic step(input string tag);
    logic [7:0] nx [32];
    logic [4:0] ev;
    #2;
    nx = mdl;
    if (window_hit() && mem_we) nx[mem_addr[4:0]] = mem_wdata;
    if (wr_en && !imm_refused()) nx[wr_addr] = wr_data;
    if (pr_en) begin
      ev = pr_base & 5'h1E;
      nx[ev]        = pr_data[7:0];
      nx[ev | 5'd1] = pr_data[15:8];
    end
    chk({"R2 ", tag}, "rd_a", 16'(rd_a_data), 16'(nx[rd_a_addr]));
    chk({"R2 ", tag}, "rd_b", 16'(rd_b_data), 16'(nx[rd_b_addr]));
    chk({"R3 ", tag}, "mem_hit", 16'(mem_hit), 16'(window_hit()));
    chk({"R3 ", tag}, "mem_rdata", 16'(mem_rdata), window_hit() ? 16'(nx[mem_addr[4:0]]) : 16'h0);
    chk({"R5 ", tag}, "imm_illegal", 16'(imm_illegal), 16'(imm_refused()));
    chk({"R4 ", tag}, "ptr_x", ptr_x, {mdl[27], mdl[26]});
    chk({"R4 ", tag}, "ptr_y", ptr_y, {mdl[29], mdl[28]});
    chk({"R4 ", tag}, "ptr_z", ptr_z, {mdl[31], mdl[30]});
    @(posedge clk);
    mdl = nx;
    @(negedge clk);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_checks++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h1CE5_0B17));
    idle();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    foreach (mdl[i]) mdl[i] = 8'h00;

    // R1: every register reads zero after reset
    for (int i = 0; i < 32; i++) begin
      idle(); rd_a_addr = 5'(i); rd_b_addr = 5'(31 - i);
      step("R1 reset readback");
    end

    // R2: forwarded byte write, then stored value
    idle(); wr_en = 1; wr_addr = 5'd3; wr_data = 8'h5A; rd_a_addr = 5'd3;
    step("R2 bypass");
    idle(); rd_a_addr = 5'd3; step("R2 stored");

    // R5: immediate into r7 refused, into r16 accepted
    idle(); wr_en = 1; wr_imm = 1; wr_addr = 5'd7; wr_data = 8'hC3; rd_a_addr = 5'd7;
    step("R5 refused");
    idle(); rd_a_addr = 5'd7; step("R5 untouched");
    idle(); wr_en = 1; wr_imm = 1; wr_addr = 5'd16; wr_data = 8'h99; rd_b_addr = 5'd16;
    step("R5 accepted");
    idle(); wr_en = 1; wr_imm = 1; wr_addr = 5'd15; wr_data = 8'h11; rd_b_addr = 5'd15;
    step("R5 boundary r15");

    // R6: product pair with odd base 1 lands in r1:r0; word pair 25:24
    idle(); pr_en = 1; pr_base = 5'd1; pr_data = 16'hBEEF; rd_a_addr = 5'd0; rd_b_addr = 5'd1;
    step("R6 product pair");
    idle(); pr_en = 1; pr_base = 5'd24; pr_data = 16'h1234; rd_a_addr = 5'd24; rd_b_addr = 5'd25;
    step("R6 word pair");

    // R7: pair beats byte port on r25; byte port beats store on r9
    idle(); pr_en = 1; pr_base = 5'd24; pr_data = 16'hA55A;
    wr_en = 1; wr_addr = 5'd25; wr_data = 8'h77; rd_a_addr = 5'd25;
    step("R7 pair over byte");
    idle(); wr_en = 1; wr_addr = 5'd9; wr_data = 8'h42;
    mem_en = 1; mem_we = 1; mem_addr = 16'h0009; mem_wdata = 8'hE1; rd_a_addr = 5'd9;
    step("R7 byte over store");

    // R3/R4: stores into the window reach the pointers; 0x0020 misses
    idle(); mem_en = 1; mem_we = 1; mem_addr = 16'h001E; mem_wdata = 8'h80;
    step("R3 store r30");
    idle(); mem_en = 1; mem_we = 1; mem_addr = 16'h001F; mem_wdata = 8'h01;
    step("R3 store r31");
    idle(); mem_en = 1; mem_we = 1; mem_addr = 16'h0020; mem_wdata = 8'hFF;
    step("R3 miss store");
    idle(); mem_en = 1; mem_addr = 16'h0000; rd_a_addr = 5'd0;
    step("R3 read r0 after miss");
    idle(); mem_en = 0; mem_we = 1; mem_addr = 16'h0005; mem_wdata = 8'h66; rd_a_addr = 5'd5;
    step("R3 disabled store");
    idle(); pr_en = 1; pr_base = 5'd27; pr_data = 16'hCAFE;
    step("R4 pair into pointer");
    idle(); step("R4 pointer view");

    // constrained random mix
    for (int s = 0; s < RAND_STEPS; s++) begin
      rd_a_addr = 5'($urandom); rd_b_addr = 5'($urandom);
      wr_en = ($urandom % 3) != 0; wr_imm = $urandom % 2;
      wr_addr = 5'($urandom); wr_data = 8'($urandom);
      pr_en = ($urandom % 4) == 0; pr_base = 5'($urandom); pr_data = 16'($urandom);
      mem_en = $urandom % 2; mem_we = $urandom % 2;
      mem_addr = ($urandom % 4 != 0) ? 16'($urandom % 32) : 16'($urandom);
      mem_wdata = 8'($urandom);
      step("random");
    end

    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

endmodule